// File: doc/BRIEF.md
# Line-Resynchronizing Dual-Clock Capture Buffer

This block carries 24-bit RGB pixels from the sample clock of an external video digitizer into the local pixel clock domain, which drives the video output. The two clocks share a nominal frequency but drift apart slowly. Rate matching is not used to absorb the drift. Each line's active pixels go into a dual-clock buffer, and reading starts once a small number of that line's pixels has been stored. At the start of each line the read pointer is realigned to the write pointer, so whatever the previous line left behind is thrown away and drift cannot build up from line to line.

A rising edge on the capture-side horizontal sync starts a line. That edge raises a flush request, which reaches the local domain through a toggle handshake. The local side jumps its read pointer to the current write pointer and returns an acknowledge. Pixels are accepted only once that acknowledge is back. The local side then emits exactly one line's worth of active words, each marked by a valid strobe. Two sticky flags, one per domain, record any pixel that could not be stored and any cycle on which the reader ran dry.

Top module: `line_resync_buffer`

## Requirements
- R1: While and after reset, `out_valid`, `ovf_flag` and `unf_flag` are all 0.
- R2: A line starts on a rising edge of `cap_hsync`. Every pixel presented with `cap_de` high is stored, and the output delivers exactly ACTIVE (1024) words per line with `out_valid` high. The words come out in capture order with nothing lost or repeated, and each word equals the captured word bit for bit (red in bits 23:16, green in 15:8, blue in 7:0).
- R3: The first `out_valid` of a line comes only after at least START_LVL (16) pixels of that line have been captured.
- R4: Entries left in the buffer from the previous line are discarded at the start of a line. The output of the new line begins with the new line's first pixel.
- R5: `ovf_flag` is set when `cap_de` is high while the block is not accepting, that is, before the flush handshake of the line has completed or while the buffer holds DEPTH entries. The flag stays set across later lines until `ovf_clr` is pulsed.
- R6: If the buffer is empty while a line is being streamed, `out_valid` stays low and `unf_flag` is set. The flag stays set across later lines until `unf_clr` is pulsed.
- R7: With the capture clock drifting against the local clock, consecutive full lines raise neither flag. The write pointer handed across the domains changes at most one bit per capture cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Capture-side sample clock |
| wr_rst | input | 1 | Synchronous active-high reset, capture domain |
| cap_pix | input | 24 | Captured pixel {red, green, blue} |
| cap_de | input | 1 | Captured pixel is active |
| cap_hsync | input | 1 | Capture horizontal sync; rising edge starts a line |
| ovf_clr | input | 1 | Clears `ovf_flag` (capture domain) |
| ovf_flag | output | 1 | Sticky: a captured pixel could not be stored |
| rd_clk | input | 1 | Local pixel clock |
| rd_rst | input | 1 | Synchronous active-high reset, local domain |
| unf_clr | input | 1 | Clears `unf_flag` (local domain) |
| out_pix | output | 24 | Output pixel, valid when `out_valid` is high |
| out_valid | output | 1 | Output pixel strobe |
| unf_flag | output | 1 | Sticky: the reader found the buffer empty mid-line |

## Verification
The assertions check on every cycle that both flags clear on reset and then hold until their own clear input arrives. They also check that no more than one line of valid words is emitted between two flushes, and that the write pointer published to the local domain moves one bit at a time. The bench scenarios cover what needs a whole line to show: the exact order and contents of each line, the number of pixels stored before reading starts, and the discarding of a previous line's leftovers. They also cover an underflow provoked by a short line, an overflow provoked by pixels sent during the flush handshake, and a clean run of several lines with the capture clock running 500 ppm slow.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    localparam int CH_W   = 8;
    localparam int PIX_W  = 3 * CH_W;
    localparam int GRAY_W = 16;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] blu;
    } pixel_t;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_FILL   = 2'd1,
        RD_STREAM = 2'd2
    } rd_state_e;

    function automatic logic [GRAY_W-1:0] to_gray(input logic [GRAY_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_W-1:0] from_gray(input logic [GRAY_W-1:0] g);
        logic [GRAY_W-1:0] b;
        b[GRAY_W-1] = g[GRAY_W-1];
        for (int i = GRAY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/lrb_sync.sv
module lrb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[s] <= '0;
                else     st[s] <= st[s-1];
            end
        end
    end

    assign q = st[STAGES-1];

endmodule

// File: rtl/lrb_ram.sv
module lrb_ram import lrb_pkg::*; #(
    parameter int AW = 12
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  pixel_t        wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output pixel_t        q
);

    localparam int DEPTH = 1 << AW;

    pixel_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) q <= mem[raddr];
    end

endmodule

// File: rtl/lrb_wr_ctrl.sv
module lrb_wr_ctrl import lrb_pkg::*; #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  pixel_t        cap_pix,
    input  logic          cap_de,
    input  logic          cap_hsync,
    input  logic          ovf_clr,
    input  logic          ack_sync,
    input  logic [AW:0]   rgray_sync,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output pixel_t        ram_wdata,
    output logic          req,
    output logic [AW:0]   wgray,
    output logic          ovf_flag
);

    localparam int PW = AW + 1;

    logic              hs_q, seen;
    logic              hs_rise, armed, full, accept;
    logic [PW-1:0]     wptr, wptr_nxt, rbin;
    logic [GRAY_W-1:0] rx, gx;

    always_comb begin
        hs_rise  = cap_hsync & ~hs_q;
        rx       = from_gray(GRAY_W'(rgray_sync));
        rbin     = rx[PW-1:0];
        full     = (wptr - rbin) == PW'(1 << AW);
        armed    = seen & (ack_sync == req);
        accept   = cap_de & armed & ~hs_rise & ~full;
        wptr_nxt = wptr + PW'(accept);
        gx       = to_gray(GRAY_W'(wptr_nxt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q     <= 1'b0;
            seen     <= 1'b0;
            req      <= 1'b0;
            wptr     <= '0;
            wgray    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            hs_q  <= cap_hsync;
            wptr  <= wptr_nxt;
            wgray <= gx[PW-1:0];
            if (hs_rise) begin
                seen <= 1'b1;
                req  <= ~req;
            end
            if (ovf_clr)                ovf_flag <= 1'b0;
            else if (cap_de && !accept) ovf_flag <= 1'b1;
        end
    end

    assign ram_we    = accept;
    assign ram_waddr = wptr[AW-1:0];
    assign ram_wdata = cap_pix;

endmodule

// File: rtl/lrb_rd_ctrl.sv
module lrb_rd_ctrl import lrb_pkg::*; #(
    parameter int AW        = 12,
    parameter int ACTIVE    = 1024,
    parameter int START_LVL = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_sync,
    input  logic [AW:0]   wgray_sync,
    input  logic          unf_clr,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    output logic          ack,
    output logic [AW:0]   rgray,
    output logic          out_valid,
    output logic          unf_flag,
    output logic          flush
);

    localparam int PW = AW + 1;
    localparam int CW = $clog2(ACTIVE + 1);

    rd_state_e         state;
    logic              req_d, req_d2;
    logic [CW-1:0]     cnt;
    logic [PW-1:0]     rptr, rptr_nxt, wbin, level;
    logic [GRAY_W-1:0] wx, rgx;
    logic              empty, fire;

    always_comb begin
        flush    = req_d ^ req_d2;
        wx       = from_gray(GRAY_W'(wgray_sync));
        wbin     = wx[PW-1:0];
        level    = wbin - rptr;
        empty    = (level == '0);
        fire     = (state == RD_STREAM) & ~empty & ~flush;
        rptr_nxt = flush ? wbin : rptr + PW'(fire);
        rgx      = to_gray(GRAY_W'(rptr_nxt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RD_IDLE;
            req_d     <= 1'b0;
            req_d2    <= 1'b0;
            ack       <= 1'b0;
            cnt       <= '0;
            rptr      <= '0;
            rgray     <= '0;
            out_valid <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            req_d     <= req_sync;
            req_d2    <= req_d;
            ack       <= req_d2;
            rptr      <= rptr_nxt;
            rgray     <= rgx[PW-1:0];
            out_valid <= fire;
            if (flush) begin
                state <= RD_FILL;
                cnt   <= '0;
            end else begin
                case (state)
                    RD_FILL: if (level >= PW'(START_LVL)) state <= RD_STREAM;
                    RD_STREAM: if (fire) begin
                        if (cnt == CW'(ACTIVE - 1)) begin
                            state <= RD_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (unf_clr)                                         unf_flag <= 1'b0;
            else if (state == RD_STREAM && empty && !flush)      unf_flag <= 1'b1;
        end
    end

    assign ram_re    = fire;
    assign ram_raddr = rptr[AW-1:0];

endmodule

// File: rtl/line_resync_buffer.sv
module line_resync_buffer import lrb_pkg::*; #(
    parameter int ADDR_W      = 12,
    parameter int ACTIVE      = 1024,
    parameter int START_LVL   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic [PIX_W-1:0] cap_pix,
    input  logic             cap_de,
    input  logic             cap_hsync,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             unf_clr,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_valid,
    output logic             unf_flag
);

    localparam int PW = ADDR_W + 1;

    logic              we, re, req, req_sync, ack, ack_sync, rd_flush;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, wgray_sync, rgray, rgray_sync;
    pixel_t            wdata, rdata;

    lrb_wr_ctrl #(.AW(ADDR_W)) i_wr (
        .clk(wr_clk), .rst(wr_rst), .cap_pix(pixel_t'(cap_pix)), .cap_de(cap_de),
        .cap_hsync(cap_hsync), .ovf_clr(ovf_clr), .ack_sync(ack_sync),
        .rgray_sync(rgray_sync), .ram_we(we), .ram_waddr(waddr), .ram_wdata(wdata),
        .req(req), .wgray(wgray), .ovf_flag(ovf_flag)
    );

    lrb_rd_ctrl #(.AW(ADDR_W), .ACTIVE(ACTIVE), .START_LVL(START_LVL)) i_rd (
        .clk(rd_clk), .rst(rd_rst), .req_sync(req_sync), .wgray_sync(wgray_sync),
        .unf_clr(unf_clr), .ram_re(re), .ram_raddr(raddr), .ack(ack), .rgray(rgray),
        .out_valid(out_valid), .unf_flag(unf_flag), .flush(rd_flush)
    );

    lrb_ram #(.AW(ADDR_W)) i_ram (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .rclk(rd_clk), .re(re), .raddr(raddr), .q(rdata)
    );

    lrb_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_wptr_sync (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_sync)
    );

    lrb_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_rptr_sync (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_sync)
    );

    lrb_sync #(.W(1), .STAGES(SYNC_STAGES)) i_req_sync (
        .clk(rd_clk), .rst(rd_rst), .d(req), .q(req_sync)
    );

    lrb_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ack_sync (
        .clk(wr_clk), .rst(wr_rst), .d(ack), .q(ack_sync)
    );

    assign out_pix = rdata;

endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
    parameter int ACTIVE = 1024,
    parameter int PW     = 13
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          ovf_flag,
    input logic          ovf_clr,
    input logic          unf_flag,
    input logic          unf_clr,
    input logic          out_valid,
    input logic          rd_flush,
    input logic [PW-1:0] wgray
);

    int unsigned vcnt;

    always_ff @(posedge rd_clk) begin
        if (rd_rst || rd_flush) vcnt <= 0;
        else if (out_valid)     vcnt <= vcnt + 1;
    end

    // R1
    ovf_reset_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $past(wr_rst) |-> !ovf_flag);

    // R1
    rd_reset_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $past(rd_rst) |-> (!out_valid && !unf_flag));

    // R5
    ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R6
    unf_sticky_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (unf_flag && !unf_clr) |=> unf_flag);

    // R2
    line_len_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        vcnt <= ACTIVE);

    // R7
    wptr_gray_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

bind line_resync_buffer lrb_checker #(.ACTIVE(ACTIVE), .PW(PW)) i_lrb_checker (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .unf_flag(unf_flag), .unf_clr(unf_clr),
    .out_valid(out_valid), .rd_flush(rd_flush), .wgray(wgray)
);

// File: tb/test_line_resync_buffer.sv
`timescale 1ns/1ps
module test_line_resync_buffer;

    localparam int ACTIVE    = 1024;
    localparam int START_LVL = 16;
    localparam int LINE_LEN  = 1344;
    localparam int HS_LEN    = 8;
    localparam int LEAD      = 192;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1;
    logic [23:0] cap_pix = '0;
    logic        cap_de = 1'b0, cap_hsync = 1'b0, ovf_clr = 1'b0, unf_clr = 1'b0;
    logic        ovf_flag, out_valid, unf_flag;
    logic [23:0] out_pix;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [23:0] got [$];
    int          wr_cnt = 0;
    bit          want_first = 1'b0;
    int          first_at = -1;

    always #4.000 rd_clk = ~rd_clk;
    always #4.002 wr_clk = ~wr_clk;

    line_resync_buffer i_line_resync_buffer (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .cap_pix(cap_pix), .cap_de(cap_de),
        .cap_hsync(cap_hsync), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .unf_clr(unf_clr), .out_pix(out_pix),
        .out_valid(out_valid), .unf_flag(unf_flag)
    );

    always @(negedge rd_clk) begin
        if (!rd_rst && out_valid) begin
            if (want_first) begin
                first_at   = wr_cnt;
                want_first = 1'b0;
            end
            got.push_back(out_pix);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One full line: sync pulse, lead-in blanking, n active pixels, trailing blanking.
    task automatic send_line(input int n, input int lid);
        int pad;
        @(negedge wr_clk);
        got.delete();
        want_first = 1'b1;
        first_at   = -1;
        wr_cnt     = 0;
        cap_hsync  = 1'b1;
        repeat (HS_LEN) @(negedge wr_clk);
        cap_hsync = 1'b0;
        repeat (LEAD) @(negedge wr_clk);
        for (int i = 0; i < n; i++) begin
            cap_de  = 1'b1;
            cap_pix = {8'(lid), 16'(i)};
            wr_cnt++;
            @(negedge wr_clk);
        end
        cap_de = 1'b0;
        pad = LINE_LEN - HS_LEN - LEAD - n;
        if (pad < 60) pad = 60;
        repeat (pad) @(negedge wr_clk);
    endtask

    task automatic check_data(input string req, input int lid, input int n);
        int bad = -1;
        chk(got.size() == n, req, "words in line", got.size(), n);
        for (int i = 0; i < n && i < got.size(); i++) begin
            if (bad < 0 && got[i] != {8'(lid), 16'(i)}) bad = i;
        end
        chk(bad < 0, req, "first out-of-order word index", bad, -1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge rd_clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        repeat (8) @(negedge wr_clk);
        wr_rst = 1'b0;
        @(negedge rd_clk);
        rd_rst = 1'b0;
        repeat (4) @(negedge rd_clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(ovf_flag == 1'b0, "R1", "ovf_flag after reset", ovf_flag, 0);
        chk(unf_flag == 1'b0, "R1", "unf_flag after reset", unf_flag, 0);
    endtask

    task automatic t_drift_lines();
        for (int l = 1; l <= 4; l++) begin
            send_line(ACTIVE, l);
            check_data("R2", l, ACTIVE);
            chk(first_at >= START_LVL, "R3", "pixels stored before first output",
                first_at, START_LVL);
            chk(first_at <= START_LVL + 10, "R3", "start latency bound",
                first_at, START_LVL + 10);
        end
        chk(ovf_flag == 1'b0, "R7", "ovf_flag after drifting lines", ovf_flag, 0);
        chk(unf_flag == 1'b0, "R7", "unf_flag after drifting lines", unf_flag, 0);
    endtask

    task automatic t_stale_flush();
        send_line(ACTIVE + 16, 20);
        chk(got.size() == ACTIVE, "R4", "long line truncated", got.size(), ACTIVE);
        send_line(ACTIVE, 21);
        chk(got.size() > 0 && got[0] == {8'd21, 16'd0}, "R4", "first word after flush",
            (got.size() > 0) ? int'(got[0]) : -1, int'({8'd21, 16'd0}));
        check_data("R4", 21, ACTIVE);
    endtask

    task automatic t_underflow();
        send_line(20, 30);
        check_data("R6", 30, 20);
        chk(unf_flag == 1'b1, "R6", "unf_flag after short line", unf_flag, 1);
        send_line(ACTIVE, 31);
        check_data("R2", 31, ACTIVE);
        chk(unf_flag == 1'b1, "R6", "unf_flag sticky", unf_flag, 1);
        @(negedge rd_clk);
        unf_clr = 1'b1;
        @(negedge rd_clk);
        unf_clr = 1'b0;
        @(negedge rd_clk);
        chk(unf_flag == 1'b0, "R6", "unf_flag cleared", unf_flag, 0);
    endtask

    task automatic t_overflow();
        @(negedge wr_clk);
        got.delete();
        cap_hsync = 1'b1;
        @(negedge wr_clk);
        for (int i = 0; i < 3; i++) begin
            cap_de  = 1'b1;
            cap_pix = {8'd40, 16'(i)};
            @(negedge wr_clk);
        end
        cap_de = 1'b0;
        repeat (HS_LEN) @(negedge wr_clk);
        cap_hsync = 1'b0;
        repeat (LINE_LEN - HS_LEN - 4) @(negedge wr_clk);
        chk(ovf_flag == 1'b1, "R5", "ovf_flag after early pixels", ovf_flag, 1);
        send_line(ACTIVE, 41);
        check_data("R2", 41, ACTIVE);
        chk(ovf_flag == 1'b1, "R5", "ovf_flag sticky", ovf_flag, 1);
        @(negedge wr_clk);
        ovf_clr = 1'b1;
        @(negedge wr_clk);
        ovf_clr = 1'b0;
        @(negedge wr_clk);
        chk(ovf_flag == 1'b0, "R5", "ovf_flag cleared", ovf_flag, 0);
    endtask

    initial begin
        t_reset();
        t_drift_lines();
        t_stale_flush();
        t_underflow();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule